// File: doc/BRIEF.md
# SPI Mode 0 Register Access Slave

This block lets an external SPI master read and write a bank of 32 byte-wide registers. The master drives chip select (active low), a serial clock that idles low, and a data line into the slave. The block returns a data line with its own output enable. Each packet starts with a command byte, sent MSB first: bit 7 picks write (1) or read (0), and bits 4:0 hold the register address. A write packet then carries one data byte. The block samples its input on the rising serial clock edge and changes its output on the falling edge.

All three serial inputs first pass through two-flop synchronizers into the system clock domain. After that, every edge is detected and handled by system-clock logic. The block reaches the register bank through an address output with a combinational read-data input, and through a one-cycle write strobe with address and data.

Once the last bit of any byte has arrived, the falling clock edge that follows loads the output shifter with the register at the most recently received address. The reply seen during a byte is therefore always the one chosen by the previous address. A write is held back until chip select rises. It is committed only if exactly 16 clock bits arrived from the start of the write command, and only if the address is marked writable in the `WR_MASK` parameter.

Top module: `spi_regacc`

## Requirements
- R1: The data input is sampled on rising serial clock edges. The data output changes only after a falling serial clock edge.
- R2: Bits are taken MSB first. In a command byte, bit 7 set means write, bit 7 clear means read, and bits 4:0 give the register address.
- R3: On the falling edge after the 8th bit of a byte, the output shifter loads the register at the most recently received address. The next 8 falling-edge shifts present that value MSB first.
- R4: After a read command, the next byte is decoded as a new command. Chip select may stay low across any number of read commands.
- R5: A write strobe is issued for one system cycle, only after chip select rises, and only when exactly 16 clock bits arrived since the write command began. Any other count discards the write.
- R6: A write to an address whose bit in `WR_MASK` is 0 (default: addresses 0 to 3) issues no strobe and leaves the register unchanged.
- R7: During a write's data byte, the old contents of the addressed register are returned. A read-back command right after the write returns the old value once more, and the new value only in the byte after it.
- R8: The output enable is low while chip select is high and high while it is low.
- R9: A falling chip select restarts the bit count and the command decoding, whatever partial bits came before it.
- R10: After reset, the output enable and write strobe are low, and the first byte shifted out is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| spi_miso_oe | output | 1 | Output enable for spi_miso |
| rd_addr | output | 5 | Register bank read address |
| rd_data | input | 8 | Register bank read data (combinational) |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 5 | Register write address |
| wr_data | output | 8 | Register write data |

## Verification
Random packets of 8, 15, 16, 17, 24 and 32 bits, with random command and data bytes, are compared bit by bit against a reference model of the reply stream and the register bank. Exactly-16-bit writes are thereby separated from writes one bit short or one bit long, and writable addresses from read-only ones. Directed chains of reads under one chip select show whether the second byte is decoded as a command. A write followed by a read-back shows whether the reply lags by one address. A stray 5-bit fragment before a valid write shows whether the falling chip select realigns the bit count.

// File: rtl/spi_regacc_pkg.sv
package spi_regacc_pkg;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_DATA = 2'd1,
        PH_TAIL = 2'd2
    } phase_e;

endpackage

// File: rtl/spi_regacc_sync.sv
module spi_regacc_sync #(
    parameter int            W   = 3,
    parameter logic [W-1:0]  RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST[i];
                stab_q <= RST[i];
            end else begin
                meta_q <= din[i];
                stab_q <= meta_q;
            end
        end
        assign dout[i] = stab_q;
    end

endmodule

// File: rtl/spi_regacc_edge.sv
module spi_regacc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_s,
    input  logic sck_s,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise,
    output logic cs_fall
);

    typedef struct packed {
        logic cs_n;
        logic sck;
    } hist_t;

    hist_t hist_d, hist_q;

    always_comb begin
        hist_d      = hist_q;
        hist_d.cs_n = cs_n_s;
        hist_d.sck  = sck_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '{cs_n: 1'b1, sck: 1'b0};
        end else begin
            hist_q <= hist_d;
        end
    end

    assign sck_rise = !cs_n_s &&  sck_s && !hist_q.sck;
    assign sck_fall = !cs_n_s && !sck_s &&  hist_q.sck;
    assign cs_rise  =  cs_n_s && !hist_q.cs_n;
    assign cs_fall  = !cs_n_s &&  hist_q.cs_n;

endmodule

// File: rtl/spi_regacc_rx.sv
module spi_regacc_rx #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          bit_stb,
    input  logic          bit_in,
    output logic          byte_done,
    output logic [DW-1:0] byte_val
);

    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    typedef struct packed {
        logic [DW-2:0] sh;
        logic [CW-1:0] cnt;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d = rx_q;
        if (restart) begin
            rx_d.cnt = '0;
        end else if (bit_stb) begin
            rx_d.sh  = {rx_q.sh[DW-3:0], bit_in};
            rx_d.cnt = (rx_q.cnt == LAST) ? '0 : rx_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign byte_done = bit_stb && !restart && (rx_q.cnt == LAST);
    assign byte_val  = {rx_q.sh, bit_in};

endmodule

// File: rtl/spi_regacc_ctrl.sv
module spi_regacc_ctrl
    import spi_regacc_pkg::*;
#(
    parameter int                 DW      = 8,
    parameter int                 AW      = 5,
    parameter logic [(1<<AW)-1:0] WR_MASK = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck_rise,
    input  logic          sck_fall,
    input  logic          cs_rise,
    input  logic          cs_fall,
    input  logic          byte_done,
    input  logic [DW-1:0] byte_val,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          tx_bit,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);

    localparam int WCW = $clog2(2 * DW + 2);
    localparam logic [WCW-1:0] WFULL = WCW'(2 * DW);
    localparam logic [WCW-1:0] WSAT  = WCW'(2 * DW + 1);
    localparam logic [WCW-1:0] WCMD  = WCW'(DW);

    typedef struct packed {
        phase_e         phase;
        logic [AW-1:0]  addr;
        logic [DW-1:0]  data;
        logic           wr_pend;
        logic [WCW-1:0] wbits;
        logic           load_pend;
        logic [DW-1:0]  tx;
        logic           wr_en;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        if (cs_fall) begin
            st_d.phase     = PH_CMD;
            st_d.wr_pend   = 1'b0;
            st_d.wbits     = '0;
            st_d.load_pend = 1'b0;
        end else begin
            if (sck_rise && st_q.wr_pend && st_q.wbits != WSAT) begin
                st_d.wbits = st_q.wbits + 1'b1;
            end
            if (byte_done) begin
                st_d.load_pend = 1'b1;
                unique case (st_q.phase)
                    PH_CMD: begin
                        st_d.addr = byte_val[AW-1:0];
                        if (byte_val[DW-1]) begin
                            st_d.phase   = PH_DATA;
                            st_d.wr_pend = 1'b1;
                            st_d.wbits   = WCMD;
                        end
                    end
                    PH_DATA: begin
                        st_d.data  = byte_val;
                        st_d.phase = PH_TAIL;
                    end
                    default: begin
                        st_d.phase = PH_TAIL;
                    end
                endcase
            end
            if (sck_fall) begin
                if (st_q.load_pend) begin
                    st_d.tx        = rd_data;
                    st_d.load_pend = 1'b0;
                end else begin
                    st_d.tx = {st_q.tx[DW-2:0], 1'b0};
                end
            end
            if (cs_rise) begin
                st_d.wr_en   = st_q.wr_pend && (st_q.wbits == WFULL) && WR_MASK[st_q.addr];
                st_d.wr_pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_CMD, addr: '0, data: '0, wr_pend: 1'b0,
                      wbits: '0, load_pend: 1'b0, tx: '0, wr_en: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_addr = st_q.addr;
    assign tx_bit  = st_q.tx[DW-1];
    assign wr_en   = st_q.wr_en;
    assign wr_addr = st_q.addr;
    assign wr_data = st_q.data;

endmodule

// File: rtl/spi_regacc.sv
module spi_regacc
    import spi_regacc_pkg::*;
#(
    parameter int                 DW      = 8,
    parameter int                 AW      = 5,
    parameter logic [(1<<AW)-1:0] WR_MASK = 32'hFFFF_FFF0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_csn,
    input  logic          spi_sck,
    input  logic          spi_mosi,
    output logic          spi_miso,
    output logic          spi_miso_oe,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_data,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);

    localparam int NSYNC = 3;

    logic [NSYNC-1:0] pins_s;
    logic             cs_n_s, sck_s, mosi_s;
    logic             sck_rise, sck_fall, cs_rise, cs_fall;
    logic             byte_done;
    logic [DW-1:0]    byte_val;

    spi_regacc_sync #(.W(NSYNC), .RST(3'b100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({spi_csn, spi_sck, spi_mosi}),
        .dout (pins_s)
    );

    assign cs_n_s = pins_s[2];
    assign sck_s  = pins_s[1];
    assign mosi_s = pins_s[0];

    spi_regacc_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n_s  (cs_n_s),
        .sck_s   (sck_s),
        .sck_rise(sck_rise),
        .sck_fall(sck_fall),
        .cs_rise (cs_rise),
        .cs_fall (cs_fall)
    );

    spi_regacc_rx #(.DW(DW)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (cs_fall),
        .bit_stb  (sck_rise),
        .bit_in   (mosi_s),
        .byte_done(byte_done),
        .byte_val (byte_val)
    );

    spi_regacc_ctrl #(.DW(DW), .AW(AW), .WR_MASK(WR_MASK)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_rise  (cs_rise),
        .cs_fall  (cs_fall),
        .byte_done(byte_done),
        .byte_val (byte_val),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .tx_bit   (spi_miso),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    assign spi_miso_oe = !cs_n_s;

endmodule

// File: rtl/spi_regacc_chk.sv
module spi_regacc_chk #(
    parameter int                 AW      = 5,
    parameter logic [(1<<AW)-1:0] WR_MASK = '1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sck_fall,
    input logic          spi_miso,
    input logic          spi_miso_oe,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr
);

    // R1: output bit moves only right after a detected falling clock edge
    a_r1_miso_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_miso_oe && $past(spi_miso_oe) && (spi_miso != $past(spi_miso)))
            |-> $past(sck_fall));

    // R5: commits happen only once the slave is deselected
    a_r5_wr_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !spi_miso_oe);

    // R5: strobe lasts a single cycle
    a_r5_wr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R6: never strobe a read-only address
    a_r6_wr_writable: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> WR_MASK[wr_addr]);

    // R8: output stays released while the strobe from deselection fires
    a_r8_oe_low_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |=> !spi_miso_oe || $past(spi_miso_oe));

endmodule

bind spi_regacc spi_regacc_chk #(.AW(AW), .WR_MASK(WR_MASK)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck_fall   (sck_fall),
    .spi_miso   (spi_miso),
    .spi_miso_oe(spi_miso_oe),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr)
);

// File: tb/spi_regacc_test.sv
module spi_regacc_test;

    localparam logic [31:0] MASK = 32'hFFFF_FFF0;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_csn = 1'b1;
    logic       spi_sck = 1'b0;
    logic       spi_mosi = 1'b0;
    logic       spi_miso, spi_miso_oe, wr_en;
    logic [4:0] rd_addr, wr_addr;
    logic [7:0] rd_data, wr_data;

    logic [7:0] bank    [32];
    logic [7:0] exp_mem [32];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model state
    logic [7:0] m_tx;
    logic [7:0] m_rx;
    logic [4:0] m_addr;
    logic [7:0] m_data;
    int         m_phase, m_cnt, m_wbits;
    bit         m_wpend, m_ld;
    logic [31:0] last_got;

    always #5 clk = ~clk;

    spi_regacc uut (
        .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    function automatic logic [7:0] init_val(input int i);
        return 8'(i * 29 + 3);
    endfunction

    assign rd_data = bank[rd_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) bank[i] <= init_val(i);
        end else if (wr_en) begin
            bank[wr_addr] <= wr_data;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_bank(input string req);
        int bad = 0;
        for (int i = 0; i < 32; i++) if (bank[i] !== exp_mem[i]) bad++;
        check(req, 32'(bad), 32'd0);
    endtask

    // one chip-select frame of n bits (MSB-aligned in bits_in)
    task automatic xfer(input logic [31:0] bits_in, input int n, input string req);
        logic [31:0] got = '0;
        logic [31:0] exp = '0;
        @(negedge clk);
        spi_csn = 1'b0;
        m_phase = 0; m_wpend = 0; m_wbits = 0; m_cnt = 0; m_ld = 0;
        repeat (6) @(negedge clk);
        check("R8 oe while selected", 32'(spi_miso_oe), 32'd1);
        for (int i = 0; i < n; i++) begin
            spi_mosi = bits_in[31 - i];
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b1;
            got[31 - i] = spi_miso;
            exp[31 - i] = m_tx[7];
            m_rx = {m_rx[6:0], bits_in[31 - i]};
            m_cnt++;
            if (m_wpend && m_wbits < 17) m_wbits++;
            if (m_cnt == 8) begin
                m_cnt = 0;
                m_ld  = 1;
                if (m_phase == 0) begin
                    m_addr = m_rx[4:0];
                    if (m_rx[7]) begin
                        m_phase = 1; m_wpend = 1; m_wbits = 8;
                    end
                end else if (m_phase == 1) begin
                    m_data  = m_rx;
                    m_phase = 2;
                end
            end
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b0;
            if (m_ld) begin
                m_tx = exp_mem[m_addr];
                m_ld = 0;
            end else begin
                m_tx = {m_tx[6:0], 1'b0};
            end
        end
        repeat (6) @(negedge clk);
        spi_csn = 1'b1;
        if (m_wpend && m_wbits == 16 && MASK[m_addr]) exp_mem[m_addr] = m_data;
        repeat (8) @(negedge clk);
        check("R8 oe released", 32'(spi_miso_oe), 32'd0);
        check({req, " reply stream"}, got, exp);
        check_bank({req, " bank contents"});
        last_got = got;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 32; i++) exp_mem[i] = init_val(i);
        m_tx = 8'h00; m_rx = '0; m_addr = '0; m_data = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R10 reset state
        check("R10 oe after reset", 32'(spi_miso_oe), 32'd0);
        check("R10 wr_en after reset", 32'(wr_en), 32'd0);

        // R10/R4: two reads under one select, then dummy
        xfer({8'h05, 8'h06, 8'h00, 8'h00}, 24, "R4 chained reads");
        check("R10 first byte zero", {24'd0, last_got[31:24]}, 32'h00);
        check("R3 R4 data of addr 5", {24'd0, last_got[23:16]}, 32'(init_val(5)));
        check("R4 data of addr 6", {24'd0, last_got[15:8]}, 32'(init_val(6)));

        // R7: write then read-back lags one address
        xfer({8'h89, 8'hA5, 16'h0}, 16, "R2 R7 write addr 9");
        check("R7 old data during write", {24'd0, last_got[23:16]}, 32'(init_val(9)));
        xfer({8'h09, 8'h00, 16'h0}, 16, "R7 read-back");
        check("R7 old data repeated", {24'd0, last_got[31:24]}, 32'(init_val(9)));
        check("R7 new data after", {24'd0, last_got[23:16]}, 32'hA5);

        // R5: wrong bit counts discard
        xfer({8'h8B, 8'h5A, 16'h0}, 15, "R5 short write");
        xfer({8'h8B, 8'h5A, 16'h0}, 17, "R5 long write");
        check("R5 addr 11 untouched", {24'd0, bank[11]}, 32'(init_val(11)));

        // R6: read-only address
        xfer({8'h82, 8'hFF, 16'h0}, 16, "R6 read-only write");
        check("R6 addr 2 untouched", {24'd0, bank[2]}, 32'(init_val(2)));

        // R9: stray fragment then valid write
        xfer({8'hF8, 24'h0}, 5, "R9 fragment");
        xfer({8'h8A, 8'h3C, 16'h0}, 16, "R9 realigned write");
        check("R9 addr 10 written", {24'd0, bank[10]}, 32'h3C);

        // random mix
        for (int k = 0; k < 160; k++) begin
            int sel = int'($urandom % 8);
            int n;
            logic [31:0] b = $urandom;
            case (sel)
                0, 1, 2: n = 16;
                3: n = 8;
                4: n = 24;
                5: n = 15;
                6: n = 17;
                default: n = 32;
            endcase
            xfer(b, n, "R1 R2 R3 R5 R6 random");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule